// File: doc/BRIEF.md
# Program Clock Reference Time Base

This block keeps the 42-bit system time used to pace decoding of an MPEG transport stream. A 9-bit extension field steps once per enabled 27 MHz cycle and wraps at 300. Each wrap advances a 33-bit base field, so the base runs at 90 kHz. The base can instead be advanced by a strobe from an external 90 kHz time source, selected by a mode input. Software seeds the whole value through two write words, so the count can be aligned with a clock reference taken from the stream.

Two interrupt pulses come out of the block. The match pulse fires when the base reaches an absolute time held in a 33-bit compare value, with a 33-bit mask that drops chosen bits from the comparison. The tick pulse fires after every N base increments, with N written by software and zero meaning off.

All registers are written through one port: `wr_en` with a 3-bit selector `wr_sel` and a 32-bit `wr_data`. The selector codes are 0 seed low, 1 seed high, 2 compare low, 3 compare high, 4 mask low, 5 mask high, 6 tick period.

Top module: `pcr_clock_core`

## Requirements
- R1: While `rst` is high at a clock edge, `pcr_value` becomes 0, `cmp_irq` and `tick_irq` become 0, and the compare, mask and tick period registers clear.
- R2: `pcr_value[8:0]` is the extension field. It steps by one on each clock where `run_en` and `tick_en` are both high, and it goes from 299 back to 0.
- R3: `pcr_value[41:9]` is the base field. With `src_ext` low it increments by one in the same cycle the extension goes from 299 to 0, and it wraps from 2^33-1 to 0.
- R4: While `run_en` is low, `pcr_value` holds its value, except when a seed load happens.
- R5: A write with selector 0 only stages `wr_data` as base bits 31:0 and leaves `pcr_value` unchanged. A write with selector 1 loads the whole value on that clock edge: base bit 32 from `wr_data[0]`, the extension from `wr_data[9:1]` (which must be below 300), and base bits 31:0 from the staged word. A load takes priority over counting.
- R6: With `src_ext` high, the base increments once on each clock where `run_en` and `ext_strobe` are high. Extension wraps no longer advance the base, but the extension keeps counting.
- R7: A bit counts as matched if its mask bit is 1 or the base bit equals the compare bit. `cmp_irq` is a single-cycle pulse one clock after the base first fully matches the compare value. A match that continues gives no further pulse, and a match that is already present when reset releases gives no pulse. Compare bits 31:0 are written with selector 2 and bit 32 with selector 3, bit 0.
- R8: A mask bit of 1 removes that base bit from the comparison. Mask bits 31:0 are written with selector 4. The mask for base bit 32 is `wr_data[0]` of a selector-5 write.
- R9: With tick period N (selector 6, `wr_data[15:0]`) nonzero, `tick_irq` pulses for one cycle on every Nth base increment, in the same cycle the new base value appears.
- R10: A tick period of 0 keeps `tick_irq` low. Writing the period restarts the count of base increments from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| run_en | input | 1 | Counting enable |
| tick_en | input | 1 | One-cycle strobe at the 27 MHz rate |
| src_ext | input | 1 | 1 = base advanced by `ext_strobe`, 0 = by extension wrap |
| ext_strobe | input | 1 | External 90 kHz strobe |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register selector |
| wr_data | input | 32 | Write data |
| pcr_value | output | 42 | {base[32:0], extension[8:0]} |
| cmp_irq | output | 1 | Absolute-time match pulse |
| tick_irq | output | 1 | Periodic tick pulse |

## Verification
Two situations are hard to reach from the ports. The first is the base rollover from 2^33-1 to 0. The second is a compare on base bit 32 alone, which would take hours of counting to reach naturally. The stimulus seeds the counter a few steps short of these points through the two seed words and then lets it run across them. It toggles the upper mask bit around a steady match to show that only bit 32 is removed from the comparison. Tick periods are tested in external-strobe mode, where each cycle can advance the base, so several periods complete in a few dozen cycles.

// File: rtl/pcr_pkg.sv
package pcr_pkg;
  typedef enum logic [2:0] {
    SEL_SEED_LO = 3'd0,
    SEL_SEED_HI = 3'd1,
    SEL_CMP_LO  = 3'd2,
    SEL_CMP_HI  = 3'd3,
    SEL_MASK_LO = 3'd4,
    SEL_MASK_HI = 3'd5,
    SEL_TICK    = 3'd6
  } pcr_sel_e;
endpackage

// File: rtl/pcr_counter.sv
module pcr_counter #(
  parameter int EXT_MOD = 300,
  parameter int EXT_W   = 9,
  parameter int BASE_W  = 33
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run_en,
  input  logic              tick_en,
  input  logic              src_ext,
  input  logic              ext_strobe,
  input  logic              load,
  input  logic [BASE_W-1:0] load_base,
  input  logic [EXT_W-1:0]  load_ext,
  output logic [BASE_W-1:0] base_q,
  output logic [EXT_W-1:0]  ext_q,
  output logic              base_step
);
  logic ext_go;
  logic ext_wrap;

  assign ext_go    = run_en & tick_en & ~load;
  assign ext_wrap  = ext_go & (ext_q == EXT_W'(EXT_MOD - 1));
  assign base_step = src_ext ? (run_en & ext_strobe & ~load) : ext_wrap;

  always_ff @(posedge clk) begin
    if (rst) begin
      ext_q  <= '0;
      base_q <= '0;
    end else if (load) begin
      ext_q  <= load_ext;
      base_q <= load_base;
    end else begin
      if (ext_go)    ext_q  <= ext_wrap ? '0 : ext_q + 1'b1;
      if (base_step) base_q <= base_q + 1'b1;
    end
  end
endmodule

// File: rtl/pcr_compare.sv
module pcr_compare #(
  parameter int BASE_W = 33,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BASE_W-1:0] base,
  input  logic              cmp_wr_lo,
  input  logic              cmp_wr_hi,
  input  logic              msk_wr_lo,
  input  logic              msk_wr_hi,
  input  logic [DATA_W-1:0] wr_data,
  output logic              irq
);
  localparam int HI_W = BASE_W - DATA_W;

  logic [BASE_W-1:0] cmp_q;
  logic [BASE_W-1:0] msk_q;
  logic [BASE_W-1:0] bit_ok;
  logic              hit;
  logic              hit_q;

  for (genvar i = 0; i < BASE_W; i++) begin : g_bit
    assign bit_ok[i] = msk_q[i] | (base[i] == cmp_q[i]);
  end
  assign hit = &bit_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_q <= '0;
      msk_q <= '0;
      hit_q <= 1'b1;
      irq   <= 1'b0;
    end else begin
      if (cmp_wr_lo) cmp_q[DATA_W-1:0]      <= wr_data;
      if (cmp_wr_hi) cmp_q[BASE_W-1:DATA_W] <= wr_data[HI_W-1:0];
      if (msk_wr_lo) msk_q[DATA_W-1:0]      <= wr_data;
      if (msk_wr_hi) msk_q[BASE_W-1:DATA_W] <= wr_data[HI_W-1:0];
      hit_q <= hit;
      irq   <= hit & ~hit_q;
    end
  end
endmodule

// File: rtl/pcr_tick.sv
module pcr_tick #(
  parameter int TICK_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              per_wr,
  input  logic [TICK_W-1:0] per_data,
  input  logic              step,
  output logic              irq
);
  logic [TICK_W-1:0] per_q;
  logic [TICK_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      per_q <= '0;
      cnt_q <= '0;
      irq   <= 1'b0;
    end else if (per_wr) begin
      per_q <= per_data;
      cnt_q <= '0;
      irq   <= 1'b0;
    end else if (step && per_q != '0) begin
      if (cnt_q == per_q - 1'b1) begin
        cnt_q <= '0;
        irq   <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
        irq   <= 1'b0;
      end
    end else begin
      irq <= 1'b0;
    end
  end
endmodule

// File: rtl/pcr_clock_core.sv
module pcr_clock_core #(
  parameter int EXT_MOD = 300,
  parameter int BASE_W  = 33,
  parameter int DATA_W  = 32,
  parameter int TICK_W  = 16
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           run_en,
  input  logic                           tick_en,
  input  logic                           src_ext,
  input  logic                           ext_strobe,
  input  logic                           wr_en,
  input  logic [2:0]                     wr_sel,
  input  logic [DATA_W-1:0]              wr_data,
  output logic [BASE_W+$clog2(EXT_MOD)-1:0] pcr_value,
  output logic                           cmp_irq,
  output logic                           tick_irq
);
  import pcr_pkg::*;

  localparam int EXT_W = $clog2(EXT_MOD);
  localparam int HI_W  = BASE_W - DATA_W;

  logic [DATA_W-1:0] seed_lo_q;
  logic [BASE_W-1:0] base_q;
  logic [EXT_W-1:0]  ext_q;
  logic              base_step;
  logic              load;

  assign load = wr_en && (wr_sel == SEL_SEED_HI);

  always_ff @(posedge clk) begin
    if (rst)                                   seed_lo_q <= '0;
    else if (wr_en && wr_sel == SEL_SEED_LO)   seed_lo_q <= wr_data;
  end

  pcr_counter #(.EXT_MOD(EXT_MOD), .EXT_W(EXT_W), .BASE_W(BASE_W)) u_cnt (
    .clk        (clk),
    .rst        (rst),
    .run_en     (run_en),
    .tick_en    (tick_en),
    .src_ext    (src_ext),
    .ext_strobe (ext_strobe),
    .load       (load),
    .load_base  ({wr_data[HI_W-1:0], seed_lo_q}),
    .load_ext   (wr_data[HI_W +: EXT_W]),
    .base_q     (base_q),
    .ext_q      (ext_q),
    .base_step  (base_step)
  );

  pcr_compare #(.BASE_W(BASE_W), .DATA_W(DATA_W)) u_cmp (
    .clk       (clk),
    .rst       (rst),
    .base      (base_q),
    .cmp_wr_lo (wr_en && wr_sel == SEL_CMP_LO),
    .cmp_wr_hi (wr_en && wr_sel == SEL_CMP_HI),
    .msk_wr_lo (wr_en && wr_sel == SEL_MASK_LO),
    .msk_wr_hi (wr_en && wr_sel == SEL_MASK_HI),
    .wr_data   (wr_data),
    .irq       (cmp_irq)
  );

  pcr_tick #(.TICK_W(TICK_W)) u_tick (
    .clk      (clk),
    .rst      (rst),
    .per_wr   (wr_en && wr_sel == SEL_TICK),
    .per_data (wr_data[TICK_W-1:0]),
    .step     (base_step),
    .irq      (tick_irq)
  );

  assign pcr_value = {base_q, ext_q};
endmodule

// File: rtl/pcr_clock_checker.sv
module pcr_clock_checker #(
  parameter int EXT_MOD = 300,
  parameter int PCR_W   = 42,
  parameter int DATA_W  = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              run_en,
  input logic              tick_en,
  input logic              src_ext,
  input logic              wr_en,
  input logic [2:0]        wr_sel,
  input logic [DATA_W-1:0] wr_data,
  input logic [PCR_W-1:0]  pcr_value,
  input logic              cmp_irq,
  input logic              tick_irq
);
  localparam int EXT_W = $clog2(EXT_MOD);

  // R7: the match pulse lasts one cycle
  p_single_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    cmp_irq |=> !cmp_irq);

  // R4: no run and no load means the value holds
  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (!rst && !run_en && !(wr_en && wr_sel == 3'd1)) |=> $stable(pcr_value));

  // R5: a high seed write lands the upper base bit and the extension
  p_seed_r5: assert property (@(posedge clk) disable iff (rst)
    (!rst && wr_en && wr_sel == 3'd1) |=>
      (pcr_value[EXT_W-1:0] == $past(wr_data[EXT_W:1]) &&
       pcr_value[PCR_W-1] == $past(wr_data[0])));

  // R2: the extension steps and wraps at the modulus
  p_ext_step_r2: assert property (@(posedge clk) disable iff (rst)
    (!rst && run_en && tick_en && !(wr_en && wr_sel == 3'd1)) |=>
      (pcr_value[EXT_W-1:0] ==
        (($past(pcr_value[EXT_W-1:0]) == EXT_W'(EXT_MOD - 1)) ? '0
                                      : $past(pcr_value[EXT_W-1:0]) + 1'b1)));

  // R9: a tick only follows a running cycle
  p_tick_running_r9: assert property (@(posedge clk) disable iff (rst)
    tick_irq |-> $past(run_en));

  // R3: in internal mode the base moves only when the extension reaches zero
  p_base_on_wrap_r3: assert property (@(posedge clk) disable iff (rst)
    (!rst && !src_ext && !(wr_en && wr_sel == 3'd1)) |=>
      ($stable(pcr_value[PCR_W-1:EXT_W]) || pcr_value[EXT_W-1:0] == '0));
endmodule

bind pcr_clock_core pcr_clock_checker #(
  .EXT_MOD(EXT_MOD), .PCR_W(BASE_W + $clog2(EXT_MOD)), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst(rst), .run_en(run_en), .tick_en(tick_en), .src_ext(src_ext),
  .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
  .pcr_value(pcr_value), .cmp_irq(cmp_irq), .tick_irq(tick_irq)
);

// File: tb/sim_pcr_clock_core.sv
`timescale 1ns/1ps
module sim_pcr_clock_core;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        run_en = 1'b0, tick_en = 1'b0, src_ext = 1'b0, ext_strobe = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_sel = 3'd0;
  logic [31:0] wr_data = 32'd0;
  logic [41:0] pcr_value;
  logic        cmp_irq, tick_irq;

  int checks = 0, errors = 0;
  int cycles = 0;
  int cmp_seen = 0, tick_seen = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pcr_clock_core u0 (
    .clk(clk), .rst(rst), .run_en(run_en), .tick_en(tick_en), .src_ext(src_ext),
    .ext_strobe(ext_strobe), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .pcr_value(pcr_value), .cmp_irq(cmp_irq), .tick_irq(tick_irq)
  );

  // behavioural reference
  localparam longint M33 = (64'd1 << 33) - 1;
  longint m_base, m_lo, m_cmp, m_msk;
  int     m_ext, m_per, m_cnt;
  bit     m_prev, m_cirq, m_tirq;

  always @(posedge clk) begin
    bit     load, ext_go, wrap, bstep, hit;
    if (rst) begin
      m_base = 0; m_lo = 0; m_cmp = 0; m_msk = 0; m_ext = 0;
      m_per = 0; m_cnt = 0; m_prev = 1; m_cirq = 0; m_tirq = 0;
    end else begin
      load   = wr_en && wr_sel == 3'd1;
      ext_go = run_en && tick_en && !load;
      wrap   = ext_go && m_ext == 299;
      bstep  = src_ext ? (run_en && ext_strobe && !load) : wrap;
      hit    = ((m_base ^ m_cmp) & ~m_msk & M33) == 0;
      m_cirq = hit && !m_prev;
      m_prev = hit;
      if (wr_en && wr_sel == 3'd6) begin
        m_per = int'(wr_data[15:0]); m_cnt = 0; m_tirq = 0;
      end else if (bstep && m_per != 0) begin
        if (m_cnt == m_per - 1) begin m_cnt = 0; m_tirq = 1; end
        else begin m_cnt++; m_tirq = 0; end
      end else m_tirq = 0;
      if (load) begin
        m_base = (longint'(wr_data[0]) << 32) | m_lo;
        m_ext  = int'(wr_data[9:1]);
      end else begin
        if (ext_go) m_ext = wrap ? 0 : m_ext + 1;
        if (bstep)  m_base = (m_base + 1) & M33;
      end
      if (wr_en && wr_sel == 3'd0) m_lo = longint'(wr_data);
      if (wr_en && wr_sel == 3'd2) m_cmp = (m_cmp & ~64'hFFFF_FFFF) | longint'(wr_data);
      if (wr_en && wr_sel == 3'd3) m_cmp = (m_cmp & 64'hFFFF_FFFF) | (longint'(wr_data[0]) << 32);
      if (wr_en && wr_sel == 3'd4) m_msk = (m_msk & ~64'hFFFF_FFFF) | longint'(wr_data);
      if (wr_en && wr_sel == 3'd5) m_msk = (m_msk & 64'hFFFF_FFFF) | (longint'(wr_data[0]) << 32);
    end
  end

  // lockstep comparison on every clock, away from the active edge
  always @(negedge clk) begin
    logic [41:0] exp_v;
    cycles++;
    if (!rst && !done) begin
      exp_v = {m_base[32:0], m_ext[8:0]};
      checks++;
      if (pcr_value !== exp_v) begin
        errors++;
        $display("FAIL R2/R3 lockstep pcr_value got %h exp %h", pcr_value, exp_v);
      end
      checks++;
      if (cmp_irq !== m_cirq) begin
        errors++;
        $display("FAIL R7 lockstep cmp_irq got %0b exp %0b", cmp_irq, m_cirq);
      end
      checks++;
      if (tick_irq !== m_tirq) begin
        errors++;
        $display("FAIL R9 lockstep tick_irq got %0b exp %0b", tick_irq, m_tirq);
      end
      if (cmp_irq)  cmp_seen++;
      if (tick_irq) tick_seen++;
    end
  end

  task automatic chk(input string tag, input longint got, input longint exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run;
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    longint b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk("R1 pcr after reset", pcr_value, 0);
    chk("R1 cmp_irq after reset", cmp_irq, 0);
    chk("R1 tick_irq after reset", tick_irq, 0);

    // R2 R3: 600 continuous steps give base 2, extension 0
    run_en = 1'b1; tick_en = 1'b1;
    idle(600);
    tick_en = 1'b0;
    @(negedge clk);
    chk("R2 extension after 600 steps", pcr_value[8:0], 0);
    chk("R3 base after 600 steps", pcr_value[41:9], 2);

    // R2: gapped strobe, one step every third cycle, 300 steps
    for (int i = 0; i < 900; i++) begin
      tick_en = (i % 3 == 0);
      @(negedge clk);
    end
    tick_en = 1'b0;
    @(negedge clk);
    chk("R2 gapped strobe base", pcr_value[41:9], 3);

    // R5: staging the low word leaves the value alone
    wr(3'd0, 32'hFFFF_FFFF);
    chk("R5 low seed write no effect", pcr_value, {33'd3, 9'd0});
    wr(3'd1, (32'd298 << 1) | 32'd1);
    chk("R5 seed load", pcr_value, {33'h1_FFFF_FFFF, 9'd298});

    // R4: freeze
    run_en = 1'b0; tick_en = 1'b1;
    idle(50);
    chk("R4 frozen value", pcr_value, {33'h1_FFFF_FFFF, 9'd298});

    // R3: base rollover at 2^33
    run_en = 1'b1;
    idle(2);
    tick_en = 1'b0;
    @(negedge clk);
    chk("R3 base wrap to zero", pcr_value, 0);

    // R7: absolute compare at base 5
    wr(3'd2, 32'd5);
    cmp_seen = 0;
    wr(3'd0, 32'd4);
    wr(3'd1, 32'd290 << 1);
    tick_en = 1'b1;
    idle(330);
    tick_en = 1'b0;
    idle(2);
    chk("R7 single match pulse", cmp_seen, 1);

    // R8: only base bit 32 compared, through the mask
    wr(3'd4, 32'hFFFF_FFFF);
    wr(3'd3, 32'd1);
    wr(3'd0, 32'hFFFF_FFFF);
    wr(3'd1, 32'd295 << 1);
    idle(2);
    cmp_seen = 0;
    tick_en = 1'b1;
    idle(10);
    tick_en = 1'b0;
    idle(2);
    chk("R8 match on bit 32 with low mask", cmp_seen, 1);
    wr(3'd5, 32'd1);
    wr(3'd3, 32'd0);
    idle(3);
    chk("R8 upper mask bit removes bit 32", cmp_seen, 1);
    wr(3'd5, 32'd0);
    idle(2);
    wr(3'd3, 32'd1);
    idle(3);
    chk("R8 bit 32 compared again", cmp_seen, 2);

    // R6 R9: external strobe mode with tick period 4
    src_ext = 1'b1; tick_en = 1'b1;
    wr(3'd6, 32'd4);
    b0 = longint'(pcr_value[41:9]);
    tick_seen = 0;
    ext_strobe = 1'b1;
    idle(12);
    ext_strobe = 1'b0;
    idle(2);
    chk("R6 base from external strobe", longint'(pcr_value[41:9]), (b0 + 12) & M33);
    chk("R9 three ticks in twelve steps", tick_seen, 3);

    // R6: extension wraps alone do not move the base
    b0 = longint'(pcr_value[41:9]);
    idle(400);
    chk("R6 no base from wrap in ext mode", longint'(pcr_value[41:9]), b0);

    // R10: period zero disables
    wr(3'd6, 32'd0);
    tick_seen = 0;
    ext_strobe = 1'b1;
    idle(12);
    ext_strobe = 1'b0;
    idle(2);
    chk("R10 period zero no tick", tick_seen, 0);

    // R10: rewriting the period restarts the count
    wr(3'd6, 32'd3);
    ext_strobe = 1'b1; idle(2); ext_strobe = 1'b0;
    wr(3'd6, 32'd3);
    tick_seen = 0;
    ext_strobe = 1'b1; idle(2); ext_strobe = 1'b0;
    idle(2);
    chk("R10 restart after period write", tick_seen, 0);
    ext_strobe = 1'b1; idle(1); ext_strobe = 1'b0;
    idle(2);
    chk("R10 tick after full period", tick_seen, 1);

    finish_run();
  end

  initial begin
    wait (cycles > 150000);
    errors++;
    $display("FAIL watchdog expired got %0d cycles exp under 150000", cycles);
    finish_run();
  end
endmodule